// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit up-counter that can take its count pulses from one of three sources: the system clock divided by four, the system clock itself, or an external count input. The chosen pulse train passes through a prescaler that divides by 1, 2, 4 or 8. Everything runs on one system clock. The external input is sampled and edge-detected at that rate, through either a two-stage synchronizer or a shorter single-stage path.

A gate can qualify counting. Its source is a gate pin (synchronized), one of two internal trigger pulses from neighbouring timers, or nothing. The gate has a polarity choice and a toggle mode, in which each active edge flips the enable so that the counter spans a full period. It also has a single-pulse acquisition mode: a go strobe arms the block, it counts across exactly one complete gate pulse, and then it reports done. Two sticky flags record counter wrap and the end of a qualified gate pulse. A single strobe clears both flags.

Top module: `gated_timer`

## Requirements
- R1: With `clk_sel_i`=01 and the prescale at divide-by-1, the counter advances on every system clock. With `clk_sel_i`=00 it advances once every four system clocks. `clk_sel_i`=11 never counts.
- R2: With `clk_sel_i`=10, the counter advances on rising edges of `ext_cnt_i`, but only after a falling edge has been seen since counting was enabled or the source was changed. `ext_sync_i`=1 samples the input through two flops and `ext_sync_i`=0 through one. Both give the same counts.
- R3: `presc_i` codes 00, 01, 10 and 11 divide the selected source by 1, 2, 4 and 8. The prescaler restarts from zero whenever `run_i` is low or `clk_sel_i` changes.
- R4: Reset clears the count, both flags and `busy_o`. While `run_i` is low the count holds.
- R5: With `gate_en_i`=1, counting happens only while the qualified gate is active. `gate_src_i` selects the gate: 00 is `gate_pin_i` after a two-flop synchronizer, 01 is `trig_a_i`, 10 is `trig_b_i`, and 11 is a gate that is never active. A direct-level gate that stays active for N clocks gives N counts.
- R6: `gate_pol_i`=1 makes a high gate source active. `gate_pol_i`=0 makes a low gate source active.
- R7: With `gate_tgl_i`=1, each rising edge of the polarity-adjusted gate flips the count enable. Two edges D clocks apart give D counts.
- R8: With `gate_sp_i`=1, a `go_set_i` strobe sets `busy_o`. The counter then counts during the first complete active gate pulse that starts after arming, and `busy_o` clears when that pulse ends. A pulse already active at arming is skipped, and pulses after done give no counts.
- R9: When the count wraps from 0xFFFF to 0x0000, `ovf_flag_o` is set. It stays set until `flag_clr_i` is pulsed.
- R10: `gate_lvl_o` shows the qualified gate level one clock after the source. With `gate_en_i`=1, the falling edge of that level sets `gate_flag_o`, which stays set until `flag_clr_i` is pulsed.
- R11: With `gate_en_i`=0, the gate has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter enable |
| clk_sel_i | input | 2 | Count source: 00 sys/4, 01 sys, 10 external, 11 none |
| presc_i | input | 2 | Prescale: divide by 2^code |
| ext_cnt_i | input | 1 | External count input |
| ext_sync_i | input | 1 | 1: two-flop sampling, 0: one-flop sampling |
| gate_en_i | input | 1 | Gate qualifies counting |
| gate_src_i | input | 2 | Gate source: 00 pin, 01 trig A, 10 trig B, 11 off |
| gate_pol_i | input | 1 | 1: active high, 0: active low |
| gate_tgl_i | input | 1 | Toggle mode |
| gate_sp_i | input | 1 | Single-pulse acquisition mode |
| go_set_i | input | 1 | Arm strobe for single-pulse mode |
| gate_pin_i | input | 1 | Gate pin, asynchronous |
| trig_a_i | input | 1 | Internal trigger A (neighbour overflow) |
| trig_b_i | input | 1 | Internal trigger B (neighbour period match) |
| flag_clr_i | input | 1 | Clears both sticky flags |
| cnt_o | output | 16 | Counter value |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| gate_flag_o | output | 1 | Sticky gate-complete flag |
| gate_lvl_o | output | 1 | Qualified gate level |
| busy_o | output | 1 | Acquisition armed or in progress |

## Verification
Nearly any wrong internal state shows up as a wrong count. A prescaler that does not restart, or a quarter divider in the wrong phase, changes the number of counts taken over a fixed window. That error appears at the end of the window, within one divide period. A lost external-edge arm gives one extra or one missing count per enable. A toggle or single-pulse flop in the wrong state either counts while the gate is idle or stalls while it is active, and `gate_lvl_o` shows this one clock later. A done that arrives early or late appears on `busy_o` at the end of the gate pulse.

// File: rtl/gtmr_pkg.sv
`timescale 1ns/1ps
package gtmr_pkg;
  typedef enum logic [1:0] {
    CS_QUARTER = 2'b00,
    CS_SYS     = 2'b01,
    CS_EXT     = 2'b10,
    CS_NONE    = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    GS_PIN    = 2'b00,
    GS_TRIG_A = 2'b01,
    GS_TRIG_B = 2'b10,
    GS_OFF    = 2'b11
  } gate_src_e;
endpackage

// File: rtl/gtmr_tick_gen.sv
`timescale 1ns/1ps
module gtmr_tick_gen
  import gtmr_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int PSC_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       clk_sel_i,
  input  logic [PSC_W-1:0] presc_i,
  input  logic             ext_i,
  input  logic             ext_sync_i,
  output logic             tick_o
);
  localparam int DIV_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int PCNT_W = (1 << PSC_W) - 1;

  logic [2:0]        ext_sh_q;
  logic              ext_smp, ext_prv, ext_rise, ext_fall;
  logic [1:0]        sel_q;
  logic              restart;
  logic              ext_armed_q;
  logic [DIV_W-1:0]  div_q;
  logic              src_tick;
  logic [PCNT_W-1:0] psc_q, psc_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sh_q <= '0;
    else         ext_sh_q <= {ext_sh_q[1:0], ext_i};
  end

  // short path taps one stage earlier
  assign ext_smp  = ext_sync_i ? ext_sh_q[1] : ext_sh_q[0];
  assign ext_prv  = ext_sync_i ? ext_sh_q[2] : ext_sh_q[1];
  assign ext_rise = ext_smp & ~ext_prv;
  assign ext_fall = ~ext_smp & ext_prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= CS_QUARTER;
    else         sel_q <= clk_sel_i;
  end

  assign restart = ~run_i | (clk_sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ext_armed_q <= 1'b0;
    else if (restart)                        ext_armed_q <= 1'b0;
    else if (ext_fall && clk_sel_i == CS_EXT) ext_armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              div_q <= '0;
    else if (restart)                         div_q <= '0;
    else if (div_q == DIV_W'(SLOW_DIV - 1))   div_q <= '0;
    else                                      div_q <= div_q + DIV_W'(1);
  end

  always_comb begin
    unique case (clk_sel_i)
      CS_QUARTER: src_tick = run_i & (div_q == DIV_W'(SLOW_DIV - 1));
      CS_SYS:     src_tick = run_i;
      CS_EXT:     src_tick = run_i & ext_armed_q & ext_rise;
      default:    src_tick = 1'b0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < PCNT_W; i++) psc_lim[i] = (i < int'(presc_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    psc_q <= '0;
    else if (restart)               psc_q <= '0;
    else if (src_tick) begin
      if (psc_q >= psc_lim)         psc_q <= '0;
      else                          psc_q <= psc_q + PCNT_W'(1);
    end
  end

  assign tick_o = src_tick & (psc_q >= psc_lim);

  // R1: quarter-rate ticks never come back to back
  a_r1_quarter_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && clk_sel_i == CS_QUARTER && $stable(clk_sel_i) && tick_o |=> !tick_o);

  // R2: no external count before the first falling edge after restart
  a_r2_ext_needs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !(clk_sel_i == CS_EXT && tick_o));
endmodule

// File: rtl/gtmr_gate.sv
`timescale 1ns/1ps
module gtmr_gate
  import gtmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] gate_src_i,
  input  logic       gate_pol_i,
  input  logic       gate_tgl_i,
  input  logic       gate_sp_i,
  input  logic       go_set_i,
  input  logic       gate_pin_i,
  input  logic       trig_a_i,
  input  logic       trig_b_i,
  output logic       gate_lvl_o,
  output logic       gate_fall_o,
  output logic       busy_o
);
  logic [1:0] pin_sync_q;
  logic       raw, gq, gq_d_q, tff_q;
  logic       gated, gated_d_q;
  logic       busy_q, sp_act_q;
  logic       eff, gval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_sync_q <= '0;
    else         pin_sync_q <= {pin_sync_q[0], gate_pin_i};
  end

  always_comb begin
    unique case (gate_src_i)
      GS_PIN:    raw = pin_sync_q[1];
      GS_TRIG_A: raw = trig_a_i;
      GS_TRIG_B: raw = trig_b_i;
      default:   raw = 1'b0;
    endcase
  end

  assign gq = (gate_src_i == GS_OFF) ? 1'b0 : (gate_pol_i ? raw : ~raw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gq_d_q    <= 1'b0;
      gated_d_q <= 1'b0;
      gval_q    <= 1'b0;
    end else begin
      gq_d_q    <= gq;
      gated_d_q <= gated;
      gval_q    <= eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tff_q <= 1'b0;
    else if (!run_i || !gate_tgl_i) tff_q <= 1'b0;
    else if (gq && !gq_d_q)        tff_q <= ~tff_q;
  end

  assign gated = gate_tgl_i ? tff_q : gq;

  // single-pulse acquisition: arm, wait for a fresh rise, done on the fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sp_act_q <= 1'b0;
    end else if (!gate_sp_i) begin
      busy_q   <= 1'b0;
      sp_act_q <= 1'b0;
    end else if (!busy_q) begin
      busy_q   <= go_set_i;
      sp_act_q <= 1'b0;
    end else if (!sp_act_q && gated && !gated_d_q) begin
      sp_act_q <= 1'b1;
    end else if (sp_act_q && !gated) begin
      busy_q   <= 1'b0;
      sp_act_q <= 1'b0;
    end
  end

  assign eff = gate_sp_i ? (busy_q & gated & (sp_act_q | ~gated_d_q)) : gated;

  assign gate_lvl_o  = gval_q;
  assign gate_fall_o = gval_q & ~eff;
  assign busy_o      = busy_q;

  // R8: done coincides with the end of the acquired pulse
  a_r8_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) && $past(gate_sp_i) && gate_sp_i |-> $fell(gval_q));

  // R8: an idle single-pulse unit never opens the gate
  a_r8_idle_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_sp_i && !busy_q |=> !gval_q);

  // R5: the disabled source never opens the gate outside toggle/single-pulse
  a_r5_off_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_src_i == GS_OFF && !gate_tgl_i |=> !gval_q);
endmodule

// File: rtl/gated_timer.sv
`timescale 1ns/1ps
module gated_timer
  import gtmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       clk_sel_i,
  input  logic [PSC_W-1:0] presc_i,
  input  logic             ext_cnt_i,
  input  logic             ext_sync_i,
  input  logic             gate_en_i,
  input  logic [1:0]       gate_src_i,
  input  logic             gate_pol_i,
  input  logic             gate_tgl_i,
  input  logic             gate_sp_i,
  input  logic             go_set_i,
  input  logic             gate_pin_i,
  input  logic             trig_a_i,
  input  logic             trig_b_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_flag_o,
  output logic             gate_flag_o,
  output logic             gate_lvl_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             tick, gate_lvl, gate_fall, inc;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, gflag_q;

  gtmr_tick_gen #(.SLOW_DIV(SLOW_DIV), .PSC_W(PSC_W)) i_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .clk_sel_i  (clk_sel_i),
    .presc_i    (presc_i),
    .ext_i      (ext_cnt_i),
    .ext_sync_i (ext_sync_i),
    .tick_o     (tick)
  );

  gtmr_gate i_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .gate_src_i  (gate_src_i),
    .gate_pol_i  (gate_pol_i),
    .gate_tgl_i  (gate_tgl_i),
    .gate_sp_i   (gate_sp_i),
    .go_set_i    (go_set_i),
    .gate_pin_i  (gate_pin_i),
    .trig_a_i    (trig_a_i),
    .trig_b_i    (trig_b_i),
    .gate_lvl_o  (gate_lvl),
    .gate_fall_o (gate_fall),
    .busy_o      (busy_o)
  );

  assign inc = run_i & tick & (~gate_en_i | gate_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + CNT_W'(1);
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q   <= 1'b0;
      gflag_q <= 1'b0;
    end else begin
      if (inc && cnt_q == CNT_MAX) ovf_q <= 1'b1;
      else if (flag_clr_i)         ovf_q <= 1'b0;
      if (gate_en_i && gate_fall)  gflag_q <= 1'b1;
      else if (flag_clr_i)         gflag_q <= 1'b0;
    end
  end

  assign cnt_o       = cnt_q;
  assign ovf_flag_o  = ovf_q;
  assign gate_flag_o = gflag_q;
  assign gate_lvl_o  = gate_lvl;

  a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));

  a_r5_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_i && !gate_lvl |=> $stable(cnt_q));

  a_r9_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> cnt_q == '0);

  a_r10_flag_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gflag_q) |-> $fell(gate_lvl));
endmodule

// File: tb/test_gated_timer.sv
`timescale 1ns/1ps
module test_gated_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  clk_sel = 2'b01;
  logic [1:0]  presc = 2'b00;
  logic        ext_cnt = 1'b0;
  logic        ext_sync = 1'b1;
  logic        gate_en = 1'b0;
  logic [1:0]  gate_src = 2'b01;
  logic        gate_pol = 1'b1;
  logic        gate_tgl = 1'b0;
  logic        gate_sp = 1'b0;
  logic        go_set = 1'b0;
  logic        gate_pin = 1'b0;
  logic        trig_a = 1'b0;
  logic        trig_b = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cnt;
  logic        ovf_flag, gate_flag, gate_lvl, busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gated_timer i_gated_timer (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .clk_sel_i(clk_sel), .presc_i(presc),
    .ext_cnt_i(ext_cnt), .ext_sync_i(ext_sync), .gate_en_i(gate_en), .gate_src_i(gate_src),
    .gate_pol_i(gate_pol), .gate_tgl_i(gate_tgl), .gate_sp_i(gate_sp), .go_set_i(go_set),
    .gate_pin_i(gate_pin), .trig_a_i(trig_a), .trig_b_i(trig_b), .flag_clr_i(flag_clr),
    .cnt_o(cnt), .ovf_flag_o(ovf_flag), .gate_flag_o(gate_flag), .gate_lvl_o(gate_lvl),
    .busy_o(busy)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_flags;
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic pulse_a(input int len);
    trig_a = 1'b1; step(len); trig_a = 1'b0;
  endtask

  task automatic t_reset;
    chk("R4 reset cnt", cnt, 0);
    chk("R4 reset flags", {ovf_flag, gate_flag, busy}, 0);
  endtask

  task automatic t_rates;
    logic [15:0] c0;
    clk_sel = 2'b01; presc = 0; gate_en = 0;
    c0 = cnt; run = 1; step(40); run = 0;
    chk("R1 sys rate", 16'(cnt - c0), 40);
    c0 = cnt; step(10);
    chk("R4 hold when off", 16'(cnt - c0), 0);
    clk_sel = 2'b00; step(1);
    c0 = cnt; run = 1; step(40); run = 0;
    chk("R1 quarter rate", 16'(cnt - c0), 10);
    clk_sel = 2'b11; step(1);
    c0 = cnt; run = 1; step(20); run = 0;
    chk("R1 no source", 16'(cnt - c0), 0);
  endtask

  task automatic t_presc;
    logic [15:0] c0;
    clk_sel = 2'b01; step(1);
    for (int p = 1; p < 4; p++) begin
      presc = 2'(p);
      c0 = cnt; run = 1; step(40); run = 0; step(1);
      chk($sformatf("R3 prescale code %0d", p), 16'(cnt - c0), 40 >> p);
    end
    presc = 2'b11;
    c0 = cnt; run = 1; step(5); run = 0; step(1); run = 1; step(6);
    chk("R3 prescaler restart", 16'(cnt - c0), 0);
    step(2);
    chk("R3 count after restart", 16'(cnt - c0), 1);
    run = 0; presc = 0; step(1);
  endtask

  task automatic t_ext(input bit sync);
    logic [15:0] c0;
    clk_sel = 2'b10; presc = 0; ext_sync = sync; ext_cnt = 0; step(4);
    c0 = cnt; run = 1;
    for (int k = 0; k < 5; k++) begin
      ext_cnt = 1; step(4); ext_cnt = 0; step(4);
    end
    step(4); run = 0;
    chk($sformatf("R2 external edges sync=%0d", sync), 16'(cnt - c0), 4);
    step(1);
  endtask

  task automatic t_gate_level;
    logic [15:0] c0;
    clk_sel = 2'b01; presc = 0; gate_en = 1; gate_src = 2'b01; gate_pol = 1;
    run = 1; clr_flags(); step(2);
    c0 = cnt; step(5);
    chk("R5 closed gate", 16'(cnt - c0), 0);
    trig_a = 1; step(3);
    chk("R10 gate level high", gate_lvl, 1);
    chk("R10 flag clear mid pulse", gate_flag, 0);
    step(7); trig_a = 0; step(3);
    chk("R5 trig A pulse count", 16'(cnt - c0), 10);
    chk("R10 gate flag set", gate_flag, 1);
    chk("R10 gate level low", gate_lvl, 0);
    clr_flags();
    chk("R10 flag cleared", gate_flag, 0);
    gate_src = 2'b10; step(2);
    c0 = cnt; pulse_a(5); step(3);
    chk("R5 unselected trig ignored", 16'(cnt - c0), 0);
    trig_b = 1; step(7); trig_b = 0; step(3);
    chk("R5 trig B pulse count", 16'(cnt - c0), 7);
    gate_src = 2'b01; gate_pol = 0; trig_a = 1; step(3);
    c0 = cnt; step(10);
    chk("R6 active low blocks high", 16'(cnt - c0), 0);
    trig_a = 0; step(10); trig_a = 1; step(3);
    chk("R6 active low counts low", 16'(cnt - c0), 10);
    trig_a = 0;
    gate_src = 2'b11; step(2);
    c0 = cnt; step(10);
    chk("R5 off source pol0", 16'(cnt - c0), 0);
    gate_pol = 1; step(2);
    c0 = cnt; step(10);
    chk("R5 off source pol1", 16'(cnt - c0), 0);
    gate_src = 2'b00; gate_pin = 0; step(4);
    c0 = cnt; gate_pin = 1; step(5);
    chk("R5 pin level seen", gate_lvl, 1);
    step(5); gate_pin = 0; step(5);
    chk("R5 pin pulse count", 16'(cnt - c0), 10);
    gate_src = 2'b01; gate_en = 0; step(1);
    c0 = cnt; step(10);
    chk("R11 gate ignored", 16'(cnt - c0), 10);
    gate_en = 1; clr_flags();
  endtask

  task automatic t_toggle;
    logic [15:0] c0;
    gate_tgl = 1; gate_pol = 1; gate_src = 2'b01; step(3);
    c0 = cnt;
    pulse_a(1); step(10);
    chk("R7 toggle level held", gate_lvl, 1);
    step(9);
    pulse_a(1); step(5);
    chk("R7 full period count", 16'(cnt - c0), 20);
    chk("R10 flag after toggle", gate_flag, 1);
    gate_tgl = 0; clr_flags(); step(2);
  endtask

  task automatic t_single;
    logic [15:0] c0;
    gate_sp = 1; gate_src = 2'b01; gate_pol = 1; step(2);
    chk("R8 idle not busy", busy, 0);
    c0 = cnt;
    go_set = 1; step(1); go_set = 0;
    chk("R8 armed busy", busy, 1);
    step(5);
    chk("R8 wait for pulse", 16'(cnt - c0), 0);
    pulse_a(6); step(3);
    chk("R8 one pulse count", 16'(cnt - c0), 6);
    chk("R8 done", busy, 0);
    pulse_a(6); step(3);
    chk("R8 later pulse ignored", 16'(cnt - c0), 6);
    trig_a = 1; step(2);
    c0 = cnt;
    go_set = 1; step(1); go_set = 0; step(3);
    trig_a = 0; step(3);
    chk("R8 partial pulse skipped", 16'(cnt - c0), 0);
    chk("R8 still busy", busy, 1);
    pulse_a(4); step(3);
    chk("R8 next full pulse", 16'(cnt - c0), 4);
    chk("R8 done again", busy, 0);
    gate_sp = 0; gate_en = 0; run = 0; step(2);
  endtask

  task automatic t_overflow;
    rst_n = 0; step(2); rst_n = 1; step(1);
    clk_sel = 2'b01; presc = 0; gate_en = 0;
    run = 1; step(65535);
    chk("R9 at max", cnt, 16'hFFFF);
    chk("R9 no flag before wrap", ovf_flag, 0);
    step(1);
    chk("R9 wraps to zero", cnt, 0);
    chk("R9 flag on wrap", ovf_flag, 1);
    step(3);
    chk("R9 flag sticky", ovf_flag, 1);
    run = 0; clr_flags();
    chk("R9 flag cleared", ovf_flag, 0);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    t_reset();
    t_rates();
    t_presc();
    t_ext(1'b1);
    t_ext(1'b0);
    t_gate_level();
    t_toggle();
    t_single();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule